// File: doc/BRIEF.md
# Reset Sequencer with Start-up Configuration Capture

This block controls the internal reset of a small processor core. It also captures a 16-bit start-up configuration word from input pins. A reset can come from three places: the active-low reset pin, a software request or a watchdog request. For each event the block holds the core in reset for a timed window, then releases it. At the moment of release it samples the configuration pins. A set of cause flags records which event produced the most recent reset.

At the start of each reset the configuration pins are ignored for a fixed window of `WIN` clock cycles. Only after that window are they taken. The value used is the one present in the cycle the internal reset is released.
- Hardware and power-on resets load both halves of the configuration word.
- Software and watchdog resets reload only the upper half. The lower half, which holds the bus-mode setting, keeps its value.

On a software or watchdog reset the block can also drive the reset pin low for `WIN` cycles. It does so only when two inputs are both 1 at the time of the request: the bidirectional-reset enable and the external-start select. The reset-pin input passes through a two-stage synchronizer. Software and watchdog requests are synchronous to the clock.

Top module: `reset_cfg_seq`

## Requirements
- R1: While `rst_ni` is low, the outputs are: `core_rst_o`=1, `pin_pull_o`=0, `flags_o`=0, `cfg_hi_o`=8'hFF and `bus_cfg_o`=8'hFF.
- R2: A low level on `ext_rst_ni` raises `core_rst_o` two cycles later. If the pin is released before the window ends, `core_rst_o` stays high for exactly `WIN`+1 cycles. `flags_o` then reads 5'b00100 (bit 2, short hardware reset).
- R3: If `ext_rst_ni` is still low when the window ends, `core_rst_o` stays high until two cycles after the pin is released. For a pin held low for H ≥ `WIN`+2 cycles, that is H cycles in total. `flags_o` then reads 5'b01000 (bit 3, long hardware reset).
- R4: The first release after `rst_ni` sets `flags_o` to 5'b10000 (bit 4, power-on).
- R5: Changes on `cfg_port_i` while `core_rst_o` is high do not alter `cfg_hi_o` or `bus_cfg_o` before release.
- R6: On release from a hardware or power-on reset, `cfg_hi_o` takes `cfg_port_i[15:8]` and `bus_cfg_o` takes `cfg_port_i[7:0]`. Both are sampled in the release cycle.
- R7: A software request while running holds `core_rst_o` high for exactly `WIN`+1 cycles and sets `flags_o` to 5'b00010 (bit 1). On release only `cfg_hi_o` is reloaded; `bus_cfg_o` keeps its value. Requests made while `core_rst_o` is high are ignored.
- R8: A watchdog request sets `flags_o` to 5'b00011 (bits 1 and 0). When a software and a watchdog request arrive in the same cycle, the watchdog encoding wins.
- R9: During a software or watchdog reset, `pin_pull_o` is high for exactly `WIN` cycles, but only if `bidir_en_i` and `ext_start_i` were both 1 in the request cycle. It is never high in any other case, including hardware resets.
- R10: `flags_o` reads zero for as long as `core_rst_o` is high.
- R11: A low level on `ext_rst_ni` during a software reset turns it into a hardware reset. Release then follows R2 or R3, with the matching flags and a reload of both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_ni | input | 1 | Reset pin level, active low, asynchronous |
| sw_req_i | input | 1 | Software reset request, one cycle |
| wdt_req_i | input | 1 | Watchdog reset request, one cycle |
| ext_start_i | input | 1 | External-start select |
| bidir_en_i | input | 1 | Bidirectional reset enable |
| cfg_port_i | input | 16 | Start-up configuration pins |
| core_rst_o | output | 1 | Internal reset to the core, active high |
| pin_pull_o | output | 1 | Open-drain pull-down enable for the reset pin |
| cfg_hi_o | output | 8 | Latched upper configuration byte |
| bus_cfg_o | output | 8 | Latched bus-mode configuration byte |
| flags_o | output | 5 | Reset cause: {power-on, long hw, short hw, software, watchdog} |

## Verification
The assertions assume three things about the inputs:
- Software and watchdog requests are single-cycle pulses.
- `ext_rst_ni` stays at each level long enough for the two-stage synchronizer to pass it.
- `cfg_port_i` settles before the release cycle.

The stimulus follows these assumptions. Every edge is driven at the falling clock edge. Each request is held for exactly one cycle. The configuration pins toggle freely during the blind part of the window, and the final word is applied twenty cycles before the earliest possible release.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_BLIND = 2'd1,
    ST_OPEN  = 2'd2,
    ST_SOFT  = 2'd3
  } rsq_state_e;

  localparam int FLAG_W   = 5;
  localparam int FL_PWR   = 4;
  localparam int FL_LONG  = 3;
  localparam int FL_SHORT = 2;
  localparam int FL_SW    = 1;
  localparam int FL_WD    = 0;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
  parameter int WIN = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == LAST);

  // saturates at WIN; the window is then over
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (en_i && !done_o)   cnt_q <= cnt_q + 1'b1;

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_sat_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o);
endmodule

// File: rtl/reset_cfg_seq.sv
module reset_cfg_seq
  import rsq_pkg::*;
#(
  parameter int WIN         = 1024,
  parameter int PORT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ext_rst_ni,
  input  logic                sw_req_i,
  input  logic                wdt_req_i,
  input  logic                ext_start_i,
  input  logic                bidir_en_i,
  input  logic [PORT_W-1:0]   cfg_port_i,
  output logic                core_rst_o,
  output logic                pin_pull_o,
  output logic [PORT_W/2-1:0] cfg_hi_o,
  output logic [PORT_W/2-1:0] bus_cfg_o,
  output logic [FLAG_W-1:0]   flags_o
);
  localparam int HALF = PORT_W / 2;

  rsq_state_e        state_q, state_d;
  logic              ext_ok, tmr_clr, tmr_done;
  logic              enter_hw, enter_sw, rel_hw, rel_sw;
  logic              por_q, pull_q, wd_q;
  logic [HALF-1:0]   cfg_hi_q, bus_q;
  logic [FLAG_W-1:0] flags_q;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_ni),
    .q_o   (ext_ok)
  );

  rsq_timer #(.WIN(WIN)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .en_i  (state_q != ST_RUN),
    .done_o(tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_clr  = 1'b0;
    enter_hw = 1'b0;
    enter_sw = 1'b0;
    rel_hw   = 1'b0;
    rel_sw   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (!ext_ok) begin
          state_d = ST_BLIND; tmr_clr = 1'b1; enter_hw = 1'b1;
        end else if (sw_req_i || wdt_req_i) begin
          state_d = ST_SOFT;  tmr_clr = 1'b1; enter_sw = 1'b1;
        end
      end
      ST_BLIND: begin
        if (tmr_done) begin
          if (ext_ok) begin state_d = ST_RUN; rel_hw = 1'b1; end
          else              state_d = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (ext_ok) begin state_d = ST_RUN; rel_hw = 1'b1; end
      end
      ST_SOFT: begin
        if (!ext_ok) begin
          state_d = ST_BLIND; tmr_clr = 1'b1;   // escalate to hardware
        end else if (tmr_done) begin
          state_d = ST_RUN; rel_sw = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_BLIND;
    else         state_q <= state_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      por_q  <= 1'b1;
      pull_q <= 1'b0;
      wd_q   <= 1'b0;
    end else begin
      if (rel_hw) por_q <= 1'b0;
      if (enter_sw) begin
        pull_q <= bidir_en_i & ext_start_i;
        wd_q   <= wdt_req_i;
      end else if (rel_sw || state_d != ST_SOFT) begin
        pull_q <= 1'b0;
      end
    end

  // capture: upper byte on every release, lower byte on hardware release only
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cfg_hi_q <= '1;
      bus_q    <= '1;
    end else begin
      if (rel_hw || rel_sw) cfg_hi_q <= cfg_port_i[PORT_W-1:HALF];
      if (rel_hw)           bus_q    <= cfg_port_i[HALF-1:0];
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) flags_q <= '0;
    else if (enter_hw || enter_sw) flags_q <= '0;
    else if (rel_hw) begin
      if (por_q)                  flags_q <= FLAG_W'(1) << FL_PWR;
      else if (state_q == ST_OPEN) flags_q <= FLAG_W'(1) << FL_LONG;
      else                        flags_q <= FLAG_W'(1) << FL_SHORT;
    end else if (rel_sw) begin
      flags_q <= (FLAG_W'(1) << FL_SW) | (FLAG_W'(wd_q) << FL_WD);
    end

  assign core_rst_o = (state_q != ST_RUN);
  assign pin_pull_o = pull_q && (state_q == ST_SOFT) && !tmr_done;
  assign cfg_hi_o   = cfg_hi_q;
  assign bus_cfg_o  = bus_q;
  assign flags_o    = flags_q;

  p_flags_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> (flags_o == '0));
  p_pull_soft_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_pull_o |-> (state_q == ST_SOFT));
  p_bus_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOFT) |=> $stable(bus_cfg_o));
  p_blind_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BLIND && !tmr_done) |=> ($stable(cfg_hi_o) && $stable(bus_cfg_o)));
  p_wd_implies_sw_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FL_WD] |-> flags_o[FL_SW]);
  p_flags_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_o[FL_WD] |-> $onehot0(flags_o));
endmodule

// File: tb/reset_cfg_seq_bench.sv
`timescale 1ns/1ps
module reset_cfg_seq_bench;
  localparam int WIN = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_rst_n = 1'b1;
  logic        sw_req = 1'b0, wdt_req = 1'b0;
  logic        ext_start = 1'b0, bidir_en = 1'b0;
  logic [15:0] cfg = 16'h0000;
  logic        core_rst, pin_pull;
  logic [7:0]  cfg_hi, bus_cfg;
  logic [4:0]  flags;

  int vectors = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  reset_cfg_seq u_reset_cfg_seq (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ext_rst_ni (ext_rst_n),
    .sw_req_i   (sw_req),
    .wdt_req_i  (wdt_req),
    .ext_start_i(ext_start),
    .bidir_en_i (bidir_en),
    .cfg_port_i (cfg),
    .core_rst_o (core_rst),
    .pin_pull_o (pin_pull),
    .cfg_hi_o   (cfg_hi),
    .bus_cfg_o  (bus_cfg),
    .flags_o    (flags)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode: 0 hw, 1 sw, 2 wdt, 3 both; esc>0: pull ext low at that iteration
  // hold: hw pin low cycles; final_w: word applied before release
  task automatic run_reset(input int mode, input int hold, input logic [15:0] final_w,
                           input int esc, output int hi_cnt, output int pull_cnt,
                           output bit blind_ok, output bit flag_ok);
    logic [7:0] hi0, bus0;
    hi0 = cfg_hi; bus0 = bus_cfg;
    hi_cnt = 0; pull_cnt = 0; blind_ok = 1'b1; flag_ok = 1'b1;
    cfg = ~final_w;
    if (mode == 0) ext_rst_n = 1'b0;
    else begin
      sw_req  = (mode == 1 || mode == 3);
      wdt_req = (mode == 2 || mode == 3);
    end
    for (int i = 1; i < 4 * WIN; i++) begin
      @(negedge clk);
      if (core_rst) hi_cnt++;
      if (pin_pull) pull_cnt++;
      if (core_rst && flags != 5'd0) flag_ok = 1'b0;
      if (core_rst && (cfg_hi != hi0 || bus_cfg != bus0)) blind_ok = 1'b0;
      sw_req = 1'b0; wdt_req = 1'b0;
      if (i == 100) sw_req = 1'b1;          // must be ignored while in reset
      if (i < WIN - 20) cfg = cfg ^ 16'(i * 16'h3B1D);
      else cfg = final_w;
      if (mode == 0 && i == hold) ext_rst_n = 1'b1;
      if (esc > 0 && i == esc) ext_rst_n = 1'b0;
      if (esc > 0 && i == esc + 5) ext_rst_n = 1'b1;
      if (hi_cnt > 0 && !core_rst) break;
    end
    sw_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  int hc, pc;
  bit bok, fok;
  logic [15:0] w;
  logic [7:0] bus_prev;

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    cfg = 16'h5AC3;
    ext_start = 1'b1; bidir_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(core_rst == 1'b1 && pin_pull == 1'b0, "R1 rst/pull", {core_rst, pin_pull}, 2'b10);
    chk(flags == 5'd0, "R1 flags", flags, 0);
    chk(cfg_hi == 8'hFF && bus_cfg == 8'hFF, "R1 cfg", {cfg_hi, bus_cfg}, 16'hFFFF);
    rst_n = 1'b1;
    hc = 0;
    for (int i = 0; i < 4 * WIN; i++) begin
      @(negedge clk);
      if (core_rst) hc++;
      else break;
    end
    chk(flags == 5'b10000, "R4 power-on flags", flags, 5'b10000);
    chk({cfg_hi, bus_cfg} == 16'h5AC3, "R6 power-on capture", {cfg_hi, bus_cfg}, 16'h5AC3);

    // short hardware resets over a set of words
    for (int n = 0; n < 6; n++) begin
      w = 16'hA5C3 ^ 16'(n * 16'h1357);
      run_reset(0, 5 + n, w, 0, hc, pc, bok, fok);
      chk(hc == WIN + 1, "R2 short duration", hc, WIN + 1);
      chk(flags == 5'b00100, "R2 short flags", flags, 5'b00100);
      chk(bok, "R5 blind hold", bok, 1);
      chk({cfg_hi, bus_cfg} == w, "R6 capture", {cfg_hi, bus_cfg}, w);
      chk(pc == 0, "R9 no pull on hw", pc, 0);
      chk(fok, "R10 flags zero", fok, 1);
    end

    // long hardware resets
    for (int n = 0; n < 2; n++) begin
      w = 16'h0F1E + 16'(n * 16'h2222);
      run_reset(0, WIN + 40 + 17 * n, w, 0, hc, pc, bok, fok);
      chk(hc == WIN + 40 + 17 * n, "R3 long duration", hc, WIN + 40 + 17 * n);
      chk(flags == 5'b01000, "R3 long flags", flags, 5'b01000);
      chk({cfg_hi, bus_cfg} == w, "R6 long capture", {cfg_hi, bus_cfg}, w);
      chk(fok, "R10 flags zero long", fok, 1);
    end

    // software / watchdog sweep over enable combinations
    for (int b = 0; b < 2; b++)
      for (int e = 0; e < 2; e++)
        for (int m = 1; m < 4; m++) begin
          bidir_en = 1'(b); ext_start = 1'(e);
          bus_prev = bus_cfg;
          w = 16'h3C00 + 16'(b * 16'h1100 + e * 16'h0600 + m * 16'h0011);
          run_reset(m, 0, w, 0, hc, pc, bok, fok);
          chk(hc == WIN + 1, "R7 soft duration", hc, WIN + 1);
          chk(cfg_hi == w[15:8], "R7 upper reload", cfg_hi, w[15:8]);
          chk(bus_cfg == bus_prev, "R7 bus kept", bus_cfg, bus_prev);
          if (m == 1) chk(flags == 5'b00010, "R7 sw flags", flags, 5'b00010);
          else        chk(flags == 5'b00011, "R8 wdt flags", flags, 5'b00011);
          chk(pc == ((b == 1 && e == 1) ? WIN : 0), "R9 pull count", pc,
              (b == 1 && e == 1) ? WIN : 0);
          chk(bok && fok, "R10 soft flags/hold", {bok, fok}, 2'b11);
        end

    // escalation of a soft reset by the pin
    w = 16'h6E91;
    run_reset(1, 0, w, 50, hc, pc, bok, fok);
    chk(flags == 5'b00100, "R11 escalated flags", flags, 5'b00100);
    chk({cfg_hi, bus_cfg} == w, "R11 full reload", {cfg_hi, bus_cfg}, w);
    chk(hc == 52 + WIN + 1, "R11 duration", hc, 52 + WIN + 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule